// File: doc/BRIEF.md
# Reset Request Aggregator

This block collects every reset request that a power controller must forward and merges them into one registered request vector. It runs on the slow always-on clock. Each peripheral hardware request passes only when its own enable bit is set. The main-power glitch request is held back while the main power domain has been switched off on purpose for low-power entry. The escalation request arrives from an unrelated fast domain and is resynchronised first.

A software reset request is accepted at the port but never reaches the vector, because a later stage generates software resets itself. The vector has one bit per peripheral source. The main-power bit sits directly above the peripheral bits, and the escalation bit sits above that.

Top module: `rst_req_aggregator`

## Requirements
- R1: While `rst_slow_ni` is low, `req_o` is all zeros, and the low-power ignore flag is clear.
- R2: Peripheral bit i of `req_o` equals `hw_req_i[i] & hw_en_i[i]` as sampled at the previous rising edge of `clk_slow_i`. A rise or a fall therefore appears one slow cycle later.
- R3: A peripheral request whose enable bit is 0 never sets its `req_o` bit.
- R4: An internal ignore flag is set at a slow edge where `main_pd_n_i` is 0 and `cause_i` is 1 (low-power entry). It is cleared at any edge where `cause_i` is not 1. Otherwise it keeps its value. The other cause codes are 0 (none) and 2 (hardware request).
- R5: The main-power bit is set one slow cycle after `main_pwr_req_i` is high, but only if the ignore flag was clear at that edge. Once set, it stays set for as long as the request stays high.
- R6: At the slow edge after `main_pwr_req_i` is low, the main-power bit is 0 whatever the ignore flag holds.
- R7: The escalation bit follows `esc_req_i` through a two-flop synchronizer. It rises and falls on the second slow edge after the input changes.
- R8: `sw_req_i` has no effect on any bit of `req_o`.
- R9: With NUM_HW peripheral sources, `req_o` is NUM_HW+2 bits wide. Bits [NUM_HW-1:0] are the peripheral bits, bit NUM_HW is the main-power bit and bit NUM_HW+1 is the escalation bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow always-on clock |
| rst_slow_ni | input | 1 | Active-low asynchronous reset, slow domain |
| hw_req_i | input | NUM_HW | Peripheral reset requests |
| hw_en_i | input | NUM_HW | Per-peripheral request enables |
| main_pwr_req_i | input | 1 | Main power glitch reset request |
| esc_req_i | input | 1 | Escalation reset request, from the fast domain |
| sw_req_i | input | 1 | Software reset request, not forwarded |
| main_pd_n_i | input | 1 | Main power domain on (1) or off (0) |
| cause_i | input | 2 | Current reset cause: 0 none, 1 low-power entry, 2 hardware request |
| req_o | output | NUM_HW+2 | Registered reset request vector |

## Verification
The assertions assume that `cause_i`, `main_pd_n_i` and the peripheral and main requests are already in the slow domain and are stable around each rising slow edge. The only input they treat as asynchronous is `esc_req_i`. The stimulus keeps to this by changing every input only on the falling edge of the slow clock. It drives cause codes 0, 1 and 2, and never the reserved code 3. Escalation pulses last at least three slow cycles, so the synchronizer never has to resolve a pulse shorter than its own depth.

// File: rtl/rra_pkg.sv
package rra_pkg;
   localparam int CAUSE_W = 2;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_LOWPWR = 2'd1,
      CAUSE_HWREQ  = 2'd2,
      CAUSE_RSVD   = 2'd3
   } cause_e;
endpackage

// File: rtl/rra_sync.sv
module rra_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             busy_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rra_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rra_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) begin
            stg_q[k] <= stg_q[k-1];
         end
      end
   end

   assign q_o    = stg_q[STAGES-1];
   assign busy_o = |stg_q;

   // R7
   sync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && d_i == '0) |=> q_o == '0);
endmodule

// File: rtl/rra_hw_gate.sv
module rra_hw_gate #(
   parameter int NUM_HW      = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_HW-1:0] req_i,
   input  logic [NUM_HW-1:0] en_i,
   output logic [NUM_HW-1:0] q_o,
   output logic              busy_o
);
   if (NUM_HW < 1) begin : g_bad_num
      $error("rra_hw_gate: NUM_HW must be at least 1");
   end
   if (SYNC_STAGES == 1) begin : g_bad_sync
      $error("rra_hw_gate: SYNC_STAGES must be 0 or at least 2");
   end

   logic [NUM_HW-1:0] gated;
   assign gated = req_i & en_i;

   if (SYNC_STAGES == 0) begin : g_direct
      logic [NUM_HW-1:0] hw_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hw_q <= '0;
         end else begin
            hw_q <= gated;
         end
      end

      assign q_o    = hw_q;
      assign busy_o = |hw_q;

      for (genvar i = 0; i < NUM_HW; i++) begin : g_chk
         // R2
         hw_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i[i] && en_i[i]) |=> q_o[i]);
         // R3
         hw_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[i] |=> !q_o[i]);
      end
   end else begin : g_synced
      rra_sync #(
         .WIDTH  (NUM_HW),
         .STAGES (SYNC_STAGES)
      ) i_hw_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (gated),
         .q_o    (q_o),
         .busy_o (busy_o)
      );
   end
endmodule

// File: rtl/rra_main_gate.sv
module rra_main_gate
   import rra_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   req_i,
   input  logic   pd_n_i,
   input  cause_e cause_i,
   output logic   main_o
);
   logic ign_q;
   logic main_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ign_q <= 1'b0;
      end else if (!pd_n_i && cause_i == CAUSE_LOWPWR) begin
         ign_q <= 1'b1;
      end else if (cause_i != CAUSE_LOWPWR) begin
         ign_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         main_q <= 1'b0;
      end else begin
         main_q <= req_i && (main_q || !ign_q);
      end
   end

   assign main_o = main_q;

   // R4
   ign_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pd_n_i && cause_i == CAUSE_LOWPWR) |=> ign_q);
   // R4
   ign_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_i != CAUSE_LOWPWR) |=> !ign_q);
   // R5
   main_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ign_q && !main_o) |=> !main_o);
   // R6
   main_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> !main_o);
endmodule

// File: rtl/rst_req_aggregator.sv
module rst_req_aggregator
   import rra_pkg::*;
#(
   parameter int NUM_HW         = 4,
   parameter int ESC_STAGES     = 2,
   parameter int HW_SYNC_STAGES = 0
) (
   input  logic                clk_slow_i,
   input  logic                rst_slow_ni,
   input  logic [NUM_HW-1:0]   hw_req_i,
   input  logic [NUM_HW-1:0]   hw_en_i,
   input  logic                main_pwr_req_i,
   input  logic                esc_req_i,
   input  logic                sw_req_i,
   input  logic                main_pd_n_i,
   input  logic [CAUSE_W-1:0]  cause_i,
   output logic [NUM_HW+1:0]   req_o
);
   localparam int MAIN_IDX = NUM_HW;
   localparam int ESC_IDX  = NUM_HW + 1;
   localparam int OUT_W    = NUM_HW + 2;

   if (NUM_HW < 1) begin : g_bad_num
      $error("rst_req_aggregator: NUM_HW must be at least 1");
   end
   if (ESC_STAGES < 2) begin : g_bad_esc
      $error("rst_req_aggregator: ESC_STAGES must be at least 2");
   end

   logic [NUM_HW-1:0] hw_q;
   logic              hw_busy;
   logic              main_q;
   logic              esc_q;
   logic              esc_busy;

   rra_hw_gate #(
      .NUM_HW      (NUM_HW),
      .SYNC_STAGES (HW_SYNC_STAGES)
   ) i_hw_gate (
      .clk_i  (clk_slow_i),
      .rst_ni (rst_slow_ni),
      .req_i  (hw_req_i),
      .en_i   (hw_en_i),
      .q_o    (hw_q),
      .busy_o (hw_busy)
   );

   rra_main_gate i_main_gate (
      .clk_i   (clk_slow_i),
      .rst_ni  (rst_slow_ni),
      .req_i   (main_pwr_req_i),
      .pd_n_i  (main_pd_n_i),
      .cause_i (cause_e'(cause_i)),
      .main_o  (main_q)
   );

   rra_sync #(
      .WIDTH  (1),
      .STAGES (ESC_STAGES)
   ) i_esc_sync (
      .clk_i  (clk_slow_i),
      .rst_ni (rst_slow_ni),
      .d_i    (esc_req_i),
      .q_o    (esc_q),
      .busy_o (esc_busy)
   );

   logic [OUT_W-1:0] vec;
   always_comb begin
      vec               = '0;
      vec[NUM_HW-1:0]   = hw_q;
      vec[MAIN_IDX]     = main_q;
      vec[ESC_IDX]      = esc_q;
   end
   assign req_o = vec;

   // R8
   sw_quiet_chk: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
      (sw_req_i && !hw_busy && (hw_req_i & hw_en_i) == '0
       && !main_pwr_req_i && !esc_busy && !esc_req_i) |=> req_o == '0);
   // R1
   reset_zero_chk: assert property (@(posedge clk_slow_i)
      !rst_slow_ni |-> req_o == '0);
endmodule

// File: tb/test_rst_req_aggregator.sv
module test_rst_req_aggregator;
   localparam int N = 4;
   localparam int W = N + 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n;
   logic [N-1:0] hr, he;
   logic         mr, er, sr, pdn;
   logic [1:0]   cause;
   logic [W-1:0] req;

   rst_req_aggregator #(.NUM_HW(N)) i_rst_req_aggregator (
      .clk_slow_i     (clk),
      .rst_slow_ni    (rst_n),
      .hw_req_i       (hr),
      .hw_en_i        (he),
      .main_pwr_req_i (mr),
      .esc_req_i      (er),
      .sw_req_i       (sr),
      .main_pd_n_i    (pdn),
      .cause_i        (cause),
      .req_o          (req)
   );

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   item_t sb[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference state built from the requirements
   logic [N-1:0] m_hw = '0;
   logic m_ign = 0, m_main = 0, m_s1 = 0, m_s2 = 0;

   task automatic cyc(input string tag);
      logic [N-1:0] nh;
      logic nign, nmain;
      item_t it;
      nh    = hr & he;
      nign  = (!pdn && cause == 2'd1) ? 1'b1 : ((cause != 2'd1) ? 1'b0 : m_ign);
      nmain = mr && (m_main || !m_ign);
      m_s2  = m_s1;
      m_s1  = er;
      m_hw  = nh;
      m_ign = nign;
      m_main = nmain;
      it.exp = {m_s2, m_main, m_hw};
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic drive(input logic [N-1:0] r, input logic [N-1:0] e,
                        input logic m, input logic x, input logic s,
                        input logic p, input logic [1:0] c,
                        input int n, input string tag);
      hr = r; he = e; mr = m; er = x; sr = s; pdn = p; cause = c;
      for (int k = 0; k < n; k++) cyc(tag);
   endtask

   // monitor
   always begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (req !== it.exp) begin
            n_fail++;
            $display("FAIL %s: req_o=%b expected %b", it.tag, req, it.exp);
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      hr = '0; he = '0; mr = 0; er = 0; sr = 0; pdn = 1; cause = 2'd0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (req !== '0) begin
         n_fail++;
         $display("FAIL R1: req_o=%b expected %b", req, {W{1'b0}});
      end
      rst_n = 1;
      @(negedge clk);

      // R2 peripheral pass-through, all enabled
      drive(4'b0001, 4'hF, 0, 0, 0, 1, 2'd0, 1, "R2");
      drive(4'b0010, 4'hF, 0, 0, 0, 1, 2'd0, 1, "R2");
      drive(4'b1010, 4'hF, 0, 0, 0, 1, 2'd0, 2, "R2");
      drive(4'b1111, 4'hF, 0, 0, 0, 1, 2'd0, 1, "R2");
      drive(4'b0000, 4'hF, 0, 0, 0, 1, 2'd0, 1, "R2");
      // R3 masked requests
      drive(4'b1111, 4'b0101, 0, 0, 0, 1, 2'd0, 2, "R3");
      drive(4'b1010, 4'b0101, 0, 0, 0, 1, 2'd0, 2, "R3");
      drive(4'b1111, 4'b0000, 0, 0, 0, 1, 2'd0, 2, "R3");
      drive(4'b0000, 4'b0000, 0, 0, 0, 1, 2'd0, 1, "R3");
      // R8 software request alone, then alongside others
      drive('0, '0, 0, 0, 1, 1, 2'd0, 3, "R8");
      drive('0, '0, 0, 0, 0, 1, 2'd0, 1, "R8");
      drive('0, '0, 0, 0, 1, 1, 2'd2, 2, "R8");
      drive(4'b0100, 4'hF, 0, 0, 1, 1, 2'd0, 2, "R8");
      drive('0, '0, 0, 0, 0, 1, 2'd0, 2, "R8");
      // R7 escalation through the synchronizer
      drive('0, '0, 0, 1, 0, 1, 2'd0, 4, "R7");
      drive('0, '0, 0, 0, 0, 1, 2'd0, 4, "R7");
      // R9 bit layout with every source active
      drive(4'b0001, 4'hF, 1, 1, 0, 1, 2'd0, 3, "R9");
      drive('0, '0, 0, 0, 0, 1, 2'd0, 3, "R9");
      // R4 ignore flag set by low-power entry, held while cause stays 1
      drive('0, '0, 0, 0, 0, 0, 2'd1, 2, "R4");
      drive('0, '0, 1, 0, 0, 1, 2'd1, 3, "R4");
      // R5 cause leaves low-power entry: flag clears, main bit then rises
      drive('0, '0, 1, 0, 0, 1, 2'd2, 3, "R5");
      // R6 main bit held while request high even if flag sets, cleared on drop
      drive('0, '0, 1, 0, 0, 0, 2'd1, 2, "R6");
      drive('0, '0, 0, 0, 0, 0, 2'd1, 2, "R6");
      drive('0, '0, 1, 0, 0, 1, 2'd0, 2, "R5");
      drive('0, '0, 0, 0, 0, 1, 2'd0, 2, "R6");

      while (sb.size() > 0) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule